// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block is the serial slave front end of a temperature supervisor. It watches oversampled clock and data lines, finds start and stop conditions, receives the address byte and data bytes, and pulls the data line low through an open-drain enable when it acknowledges or sends a zero. Behind the serial engine sits a small register bank. The bank holds the alarm configuration, the conversion-rate code and four alarm thresholds. It also returns the measured values and the status byte, which other logic supplies. Reads and writes of the same register use different register numbers. The first data byte of every write transfer loads a register pointer, and any later byte of that transfer is stored at the pointer. A read transfer returns the register the pointer selects.

The slave takes its 7-bit bus address from two three-level strap inputs, which are captured while reset is held. When the alert input is active, the slave also answers the shared alert-response address. It returns its own address, and it drops out if another responder wins bit-wise arbitration on the line.

The controller is a seven-state machine:
- IDLE waits for a start.
- ADDR shifts in the address byte.
- ACK drives the acknowledge bit.
- RX takes in a write byte.
- TX sends a read byte.
- TXACK samples the master's acknowledge.
- SKIP ignores the bus until the next start or stop.

The transitions are:
- start moves any state to ADDR, and stop moves any state to IDLE.
- ADDR goes to ACK on a matching address and to SKIP on any other address.
- ACK goes to TX for a read and to RX for a write.
- RX returns to ACK after eight bits.
- TX goes to TXACK after eight bits, or to SKIP when arbitration is lost.
- TXACK goes back to TX when the master acknowledges, and to SKIP when it does not.

Top module: `smb_regif`

## Requirements
- R1: After reset the writable registers read back as follows: configuration 00h, rate 02h, local high limit 7Fh, local low limit C9h, remote high limit 7Fh, remote low limit C9h. The one-shot strobe is low, the data line is released, and the register pointer is 00h.
- R2: Each strap input is coded 00 = low, 01 = high, 10 or 11 = floating. The bus address is chosen by pin_a0 (group) and pin_a1 (offset):
  - pin_a0 low gives 18h/19h/1Ah.
  - pin_a0 floating gives 29h/2Ah/2Bh.
  - pin_a0 high gives 4Ch/4Dh/4Eh.
  - Within each group the offset is low +0, floating +1, high +2.
  - The address is captured only while rst_n is low, so later strap changes have no effect.
- R3: The slave acknowledges its own address by holding SDA low for the ninth clock. It never drives SDA for any other address.
- R4: The first data byte of a write sets the pointer. Each later byte is written to the register the pointer selects: 09h configuration, 0Ah rate, 0Bh local high, 0Ch local low, 0Dh remote high, 0Eh remote low.
- R5: A read returns the byte at the pointer, MSB first:
  - 00h local value, 01h remote value, 02h status.
  - 03h configuration, 04h rate.
  - 05h to 08h the four limits, in the order local high, local low, remote high, remote low.
  - The pointer does not advance, so a master that acknowledges gets the same byte again.
- R6: Read pointer FEh returns the identifier 41h, and FFh returns the revision 03h.
- R7: A write with pointer 0Fh produces exactly one single-cycle pulse on oneshot_o and changes no register.
- R8: A read at a write-only or unused pointer returns 00h. A write at a read-only pointer is ignored.
- R9: When alert_i is high, the slave acknowledges a read to 0Ch and returns {own address, 0}. When alert_i is low, it does not acknowledge 0Ch.
- R10: While sending the alert response, a slave that releases SDA for a 1 but sees 0 stops driving for the rest of the transfer.
- R11: After the master NACKs a read byte, the slave keeps SDA released until the next start.
- R12: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A repeated start begins a new address phase, and a stop in the middle of a byte aborts the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; the straps are captured while it is low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_a0 | input | 2 | Group strap, three-level code |
| pin_a1 | input | 2 | Offset strap, three-level code |
| alert_i | input | 1 | Alert condition active |
| local_temp_i | input | 8 | Local measured value |
| remote_temp_i | input | 8 | Remote measured value |
| status_i | input | 8 | Status byte |
| cfg_o | output | 8 | Configuration register |
| rate_o | output | 8 | Conversion-rate register |
| loc_hi_o | output | 8 | Local high limit |
| loc_lo_o | output | 8 | Local low limit |
| rem_hi_o | output | 8 | Remote high limit |
| rem_lo_o | output | 8 | Remote low limit |
| oneshot_o | output | 1 | Single-cycle conversion request |

## Verification
The bench changes the straps after reset and checks that the slave answers only the address captured during reset. A slave that re-sampled the straps would acknowledge the new address. The bench reads the write-only, unused and identifier pointers, and writes to a read-only pointer. A design that folded the read and write numbers together would return or corrupt live register data. The bench runs the alert-response read twice: once alone, and once against a lower-addressed competitor. A slave that kept driving after losing arbitration would corrupt the byte the master receives. The bench also clocks on past a master NACK, where a slave that kept sending would pull data bits low, and it checks repeated starts and a stop in the middle of a byte.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_TXACK, ST_SKIP
    } smb_state_t;

    localparam logic [6:0] ARA_ADDR  = 7'h0C;
    localparam logic [1:0] PIN_LOW   = 2'b00;
    localparam logic [1:0] PIN_HIGH  = 2'b01;
endpackage

// File: rtl/smb_linemon.sv
module smb_linemon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_p, sda_p;
    logic scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
            scl_p <= scl_s;
            sda_p <= sda_hi;
        end
    end

    assign scl_s     = scl_q[SYNC_STAGES-1];
    assign sda_hi    = sda_q[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_hi;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_hi;
endmodule

// File: rtl/smb_devsel.sv
module smb_devsel
    import smb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pin_a0,
    input  logic [1:0] pin_a1,
    output logic [6:0] dev_addr
);
    logic [6:0] base, offs;

    always_comb begin
        unique case (pin_a0)
            PIN_LOW:  base = 7'h18;
            PIN_HIGH: base = 7'h4C;
            default:  base = 7'h29;
        endcase
        unique case (pin_a1)
            PIN_LOW:  offs = 7'd0;
            PIN_HIGH: offs = 7'd2;
            default:  offs = 7'd1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dev_addr <= base + offs;
        else        dev_addr <= dev_addr;
    end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
    parameter int         DW     = 8,
    parameter logic [7:0] DEV_ID = 8'h41,
    parameter logic [7:0] REV_ID = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    ptr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] local_t,
    input  logic [DW-1:0] remote_t,
    input  logic [DW-1:0] status,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] cfg,
    output logic [DW-1:0] rate,
    output logic [DW-1:0] lh,
    output logic [DW-1:0] ll,
    output logic [DW-1:0] rh,
    output logic [DW-1:0] rl,
    output logic          oneshot
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= 8'h00; rate <= 8'h02;
            lh  <= 8'h7F; ll   <= 8'hC9;
            rh  <= 8'h7F; rl   <= 8'hC9;
            oneshot <= 1'b0;
        end else begin
            oneshot <= 1'b0;
            if (wr_en) begin
                case (ptr)
                    8'h09: cfg  <= wr_data;
                    8'h0A: rate <= wr_data;
                    8'h0B: lh   <= wr_data;
                    8'h0C: ll   <= wr_data;
                    8'h0D: rh   <= wr_data;
                    8'h0E: rl   <= wr_data;
                    8'h0F: oneshot <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (ptr)
            8'h00:   rd_data = local_t;
            8'h01:   rd_data = remote_t;
            8'h02:   rd_data = status;
            8'h03:   rd_data = cfg;
            8'h04:   rd_data = rate;
            8'h05:   rd_data = lh;
            8'h06:   rd_data = ll;
            8'h07:   rd_data = rh;
            8'h08:   rd_data = rl;
            8'hFE:   rd_data = DEV_ID;
            8'hFF:   rd_data = REV_ID;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/smb_regif.sv
module smb_regif
    import smb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] pin_a0,
    input  logic [1:0] pin_a1,
    input  logic       alert_i,
    input  logic [7:0] local_temp_i,
    input  logic [7:0] remote_temp_i,
    input  logic [7:0] status_i,
    output logic [7:0] cfg_o,
    output logic [7:0] rate_o,
    output logic [7:0] loc_hi_o,
    output logic [7:0] loc_lo_o,
    output logic [7:0] rem_hi_o,
    output logic [7:0] rem_lo_o,
    output logic       oneshot_o
);
    smb_state_t state, state_nx;
    logic sda_hi, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] dev_addr;
    logic [7:0] sh, byte_in, tx_sh, tx_byte, ptr, wr_data, rd_data;
    logic [3:0] bit_cnt;
    logic drive_lo, ack_on, rd_mode, ara_mode, byte_idx, m_nack, wr_en;
    logic addr_hit, arb_lost;

    smb_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk, .rst_n, .scl_i, .sda_i, .sda_hi, .scl_rise, .scl_fall,
        .start_det, .stop_det);

    smb_devsel u_dev (.clk, .rst_n, .pin_a0, .pin_a1, .dev_addr);

    smb_regbank u_bank (
        .clk, .rst_n, .wr_en, .ptr, .wr_data,
        .local_t(local_temp_i), .remote_t(remote_temp_i), .status(status_i),
        .rd_data, .cfg(cfg_o), .rate(rate_o), .lh(loc_hi_o), .ll(loc_lo_o),
        .rh(rem_hi_o), .rl(rem_lo_o), .oneshot(oneshot_o));

    assign byte_in  = {sh[6:0], sda_hi};
    assign addr_hit = (byte_in[7:1] == dev_addr) ||
                      (byte_in[7:1] == ARA_ADDR && byte_in[0] && alert_i);
    assign tx_byte  = ara_mode ? {dev_addr, 1'b0} : rd_data;
    assign arb_lost = scl_rise && ara_mode && !drive_lo && !sda_hi;
    assign sda_oe   = drive_lo;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (stop_det)       state_nx = ST_IDLE;
        else if (start_det) state_nx = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR:  if (scl_rise && bit_cnt == 4'd7)
                              state_nx = addr_hit ? ST_ACK : ST_SKIP;
                ST_ACK:   if (scl_fall && ack_on)
                              state_nx = rd_mode ? ST_TX : ST_RX;
                ST_RX:    if (scl_rise && bit_cnt == 4'd7) state_nx = ST_ACK;
                ST_TX:    if (arb_lost) state_nx = ST_SKIP;
                          else if (scl_fall && bit_cnt == 4'd8) state_nx = ST_TXACK;
                ST_TXACK: if (scl_fall) state_nx = m_nack ? ST_SKIP : ST_TX;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; tx_sh <= '0; ptr <= 8'h00; wr_data <= '0;
            bit_cnt <= '0; drive_lo <= 1'b0; ack_on <= 1'b0;
            rd_mode <= 1'b0; ara_mode <= 1'b0; byte_idx <= 1'b0;
            m_nack <= 1'b0; wr_en <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0; drive_lo <= 1'b0; ack_on <= 1'b0; byte_idx <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_SKIP: drive_lo <= 1'b0;
                    ST_ADDR: if (scl_rise) begin
                        sh <= byte_in;
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == 4'd7) begin
                            rd_mode  <= byte_in[0];
                            ara_mode <= (byte_in[7:1] == ARA_ADDR);
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!ack_on) begin
                            drive_lo <= 1'b1;
                            ack_on   <= 1'b1;
                        end else begin
                            ack_on  <= 1'b0;
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                tx_sh    <= tx_byte;
                                drive_lo <= ~tx_byte[7];
                            end else begin
                                drive_lo <= 1'b0;
                            end
                        end
                    end
                    ST_RX: if (scl_rise) begin
                        sh <= byte_in;
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == 4'd7) begin
                            if (!byte_idx) ptr <= byte_in;
                            else begin
                                wr_en   <= 1'b1;
                                wr_data <= byte_in;
                            end
                            byte_idx <= 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                            if (arb_lost) drive_lo <= 1'b0;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) drive_lo <= 1'b0;
                            else begin
                                tx_sh    <= {tx_sh[6:0], 1'b0};
                                drive_lo <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) m_nack <= sda_hi;
                        else if (scl_fall && !m_nack) begin
                            tx_sh    <= tx_byte;
                            drive_lo <= ~tx_byte[7];
                            bit_cnt  <= '0;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_regif_chk.sv
module smb_regif_chk
    import smb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input smb_state_t state,
    input logic       sda_oe,
    input logic       oneshot,
    input logic       wr_en,
    input logic [6:0] dev_addr,
    input logic [7:0] cfg
);
    AST_DEV_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(dev_addr));                                   // R2
    AST_ONESHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot |=> !oneshot);                                          // R7
    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));                                       // R4
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe);                                  // R12
    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SKIP |-> !sda_oe);                                  // R11
endmodule

bind smb_regif smb_regif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_oe(sda_oe),
    .oneshot(oneshot_o), .wr_en(wr_en), .dev_addr(dev_addr), .cfg(cfg_o));

// File: tb/tb_smb_regif.sv
module tb_smb_regif;
    localparam int Q = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, sda_x = 1'b1;
    logic [1:0] pin_a0 = 2'b10, pin_a1 = 2'b01;   // floating / high -> 2Bh
    logic alert = 1'b0;
    logic [7:0] loc_t = 8'h2D, rem_t = 8'h3C, stat = 8'h48;
    logic sda_oe, oneshot;
    logic [7:0] cfg, rate, lh, ll, rh, rl;
    wire  sda_bus = sda_m & sda_x & ~sda_oe;

    int vectors = 0, fails = 0, pulses = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rd_val;
    event       rd_ev;
    bit         done = 0;

    always #4 clk = ~clk;

    smb_regif dut (
        .clk, .rst_n, .scl_i(scl), .sda_i(sda_bus), .sda_oe,
        .pin_a0, .pin_a1, .alert_i(alert),
        .local_temp_i(loc_t), .remote_temp_i(rem_t), .status_i(stat),
        .cfg_o(cfg), .rate_o(rate), .loc_hi_o(lh), .loc_lo_o(ll),
        .rem_hi_o(rh), .rem_lo_o(rl), .oneshot_o(oneshot));

    always @(posedge clk) if (oneshot) pulses <= pulses + 1;

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // monitor: pops expected items as read bytes arrive
    initial forever begin
        @(rd_ev);
        if (exp_q.size() == 0) check("unexpected read", rd_val, 8'hxx);
        else check(tag_q.pop_front(), rd_val, exp_q.pop_front());
    end

    task automatic expect_rd(string tag, logic [7:0] v);
        exp_q.push_back(v); tag_q.push_back(tag);
    endtask

    task automatic w(); repeat (Q) @(negedge clk); endtask
    task automatic bstart(); sda_m = 1; w(); scl = 1; w(); sda_m = 0; w(); scl = 0; w(); endtask
    task automatic bstop();  sda_m = 0; w(); scl = 1; w(); sda_m = 1; w(); endtask
    task automatic sbit(logic b); sda_m = b; w(); scl = 1; w(); w(); scl = 0; w(); endtask
    task automatic rbit(output logic b, input logic other);
        sda_m = 1; sda_x = other; w(); scl = 1; w(); b = sda_bus; w(); scl = 0; w(); sda_x = 1;
    endtask
    task automatic wbyte(logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) sbit(v[i]);
        rbit(a, 1'b1); ack = ~a;
    endtask
    task automatic rbyte(output logic [7:0] v, input logic mack, input logic [7:0] other);
        for (int i = 7; i >= 0; i--) rbit(v[i], other[i]);
        sbit(~mack);
    endtask

    logic [6:0] dev = 7'h2B;
    task automatic reg_write(logic [7:0] p, logic [7:0] d);
        logic a;
        bstart(); wbyte({dev, 1'b0}, a); wbyte(p, a); wbyte(d, a); bstop();
    endtask
    task automatic set_ptr(logic [7:0] p);
        logic a;
        bstart(); wbyte({dev, 1'b0}, a); wbyte(p, a); bstop();
    endtask
    task automatic reg_read();
        logic a; logic [7:0] v;
        bstart(); wbyte({dev, 1'b1}, a); rbyte(v, 1'b0, 8'hFF); bstop();
        rd_val = v; ->rd_ev; w();
    endtask
    task automatic probe(logic [7:0] b, output logic ack);
        bstart(); wbyte(b, ack); bstop();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic a; logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        pin_a0 = 2'b00; pin_a1 = 2'b00;     // changes after reset: no effect (R2)
        w();
        // R1 reset state
        check("R1 cfg", cfg, 8'h00);   check("R1 rate", rate, 8'h02);
        check("R1 lh", lh, 8'h7F);     check("R1 ll", ll, 8'hC9);
        check("R1 rh", rh, 8'h7F);     check("R1 rl", rl, 8'hC9);
        check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
        check("R1 oneshot", {7'd0, oneshot}, 8'h00);
        // R5/R1 pointer defaults to local value
        expect_rd("R5 read after reset", 8'h2D); reg_read();
        // R2 / R3 addressing
        probe({7'h18, 1'b0}, a); check("R2 new strap ignored", {7'd0, a}, 8'h00);
        probe({7'h2A, 1'b0}, a); check("R3 foreign addr no ack", {7'd0, a}, 8'h00);
        probe({7'h2B, 1'b0}, a); check("R3 own addr ack", {7'd0, a}, 8'h01);
        // R4 writes
        reg_write(8'h09, 8'h80); reg_write(8'h0A, 8'h05);
        reg_write(8'h0B, 8'h55); reg_write(8'h0C, 8'hE0);
        reg_write(8'h0D, 8'h64); reg_write(8'h0E, 8'hF6);
        check("R4 cfg", cfg, 8'h80);   check("R4 rate", rate, 8'h05);
        check("R4 lh", lh, 8'h55);     check("R4 ll", ll, 8'hE0);
        check("R4 rh", rh, 8'h64);     check("R4 rl", rl, 8'hF6);
        // R5 read map
        begin
            logic [7:0] ex [9] = '{8'h2D, 8'h3C, 8'h48, 8'h80, 8'h05, 8'h55, 8'hE0, 8'h64, 8'hF6};
            for (int i = 0; i < 9; i++) begin
                set_ptr(8'(i)); expect_rd($sformatf("R5 read ptr %02h", i), ex[i]); reg_read();
            end
        end
        // R6 identifiers
        set_ptr(8'hFE); expect_rd("R6 id", 8'h41); reg_read();
        set_ptr(8'hFF); expect_rd("R6 revision", 8'h03); reg_read();
        // R8 write-only / unused reads, read-only write
        set_ptr(8'h09); expect_rd("R8 write-only read", 8'h00); reg_read();
        set_ptr(8'h20); expect_rd("R8 unused read", 8'h00); reg_read();
        reg_write(8'h03, 8'hAA);
        check("R8 read-only write ignored", cfg, 8'h80);
        // R7 one-shot
        reg_write(8'h0F, 8'h5A);
        check("R7 one pulse", 8'(pulses), 8'h01);
        check("R7 rate unchanged", rate, 8'h05);
        set_ptr(8'h0F); expect_rd("R7 no storage", 8'h00); reg_read();
        // R9 alert response
        alert = 0; probe({7'h0C, 1'b1}, a); check("R9 no alert no ack", {7'd0, a}, 8'h00);
        alert = 1;
        bstart(); wbyte({7'h0C, 1'b1}, a); check("R9 ack", {7'd0, a}, 8'h01);
        rbyte(v, 1'b0, 8'hFF); bstop();
        rd_val = v; expect_rd("R9 returns own addr", 8'h56); ->rd_ev; w();
        // R10 arbitration against competitor at 18h
        bstart(); wbyte({7'h0C, 1'b1}, a);
        rbyte(v, 1'b0, 8'h30); bstop();
        rd_val = v; expect_rd("R10 lost arbitration released", 8'h30); ->rd_ev; w();
        alert = 0;
        // R11 acked reread then NACK release; R5 pointer not advanced
        set_ptr(8'h05);
        bstart(); wbyte({dev, 1'b1}, a);
        rbyte(v, 1'b1, 8'hFF); rd_val = v; expect_rd("R5 first byte", 8'h55); ->rd_ev; w();
        rbyte(v, 1'b0, 8'hFF); rd_val = v; expect_rd("R5 same byte again", 8'h55); ->rd_ev; w();
        rbyte(v, 1'b0, 8'hFF); rd_val = v; expect_rd("R11 released after NACK", 8'hFF); ->rd_ev; w();
        bstop();
        // R12 repeated start and mid-byte stop
        bstart(); wbyte({dev, 1'b0}, a); wbyte(8'h07, a);
        bstart(); wbyte({dev, 1'b1}, a); rbyte(v, 1'b0, 8'hFF); bstop();
        rd_val = v; expect_rd("R12 repeated start", 8'h64); ->rd_ev; w();
        bstart(); sbit(1'b0); sbit(1'b1); sbit(1'b0); bstop();
        expect_rd("R12 after aborted byte", 8'h64); reg_read();
        check("R12 idle released", {7'd0, sda_oe}, 8'h00);
        w();
        if (exp_q.size() != 0) check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        finish_run();
    end
endmodule